// File: doc/BRIEF.md
# Outstanding Memory Transaction Table with Resource-Gated Issue

This block holds up to 32 memory transactions in flight between requesters and the memory side. Each arriving request has its address compared at once against the youngest live entry for every address. A new address is allocated a fresh entry. A request to an address that is still busy is parked behind the older entry. A response is folded into the issued entry it belongs to, and the coherence state recorded when that entry was allocated is returned with it.

Entries that are pending and not blocked compete for issue. Each transaction class needs one of three single-occupancy resources, and a scoreboard records which resources are held. A two-stage issue path picks one entry per cycle with a rotating pointer, then commits that pick on the next edge. The pick stage is told about the commit still in flight, so the same entry and the same resource are never granted twice. Retiring a completed entry frees its slot and releases any entry queued behind it.

Top module: `txn_inflight_table`

## Requirements
- R1: After reset no entry is live, all resources are free, and `dec_valid` and `iss_valid` are low.
- R2: A request (`in_is_resp`=0) whose address matches no live entry is allocated the lowest free index and reported with `dec_kind`=0 on the next edge.
- R3: A request whose address matches a live entry is placed in the lowest free index with `dec_kind`=1. It is not issued while the older entry is live, and it becomes eligible once that entry retires.
- R4: A response (`in_is_resp`=1) whose address matches an issued entry is reported with `dec_kind`=2, that entry's index and, on `dec_coh`, the coherence state given when the entry was allocated. The entry is then complete.
- R5: A response that matches no issued entry, or a request that arrives while all entries are live, is reported with `dec_kind`=3 and leaves the table unchanged.
- R6: Classes 0 and 1 use resource 0, classes 2 and 3 use resource 1, and class 4 uses resource 2. An entry issues only while its resource is free. Issuing holds the resource until the matching `res_release` bit is pulsed.
- R7: A request allocated on edge E, with its resource free and no other eligible entry, gives a one-cycle `iss_valid` after edge E+2, carrying its index, class and address.
- R8: At most one entry issues per cycle, an entry issues at most once per allocation, and no resource is granted to two entries.
- R9: After entry k issues, the search for the next issue starts at index k+1 and wraps from the last index to 0.
- R10: `ret_valid` frees entry `ret_idx` only if that entry is complete. A retire aimed at any other entry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming transaction present |
| in_is_resp | input | 1 | 1 = response, 0 = request |
| in_addr | input | ADDR_W | Transaction address |
| in_class | input | 3 | Transaction class, 0 to 4 |
| in_coh | input | COH_W | Coherence state requested |
| ret_valid | input | 1 | Retire strobe |
| ret_idx | input | 5 | Entry to retire |
| res_release | input | N_RES | One bit per resource, pulse to free it |
| dec_valid | output | 1 | Decision for last edge's input |
| dec_kind | output | 2 | 0 alloc, 1 serialize, 2 merge, 3 reject |
| dec_idx | output | 5 | Entry index of the decision |
| dec_coh | output | COH_W | Coherence state of the merged entry |
| iss_valid | output | 1 | One entry issued |
| iss_idx | output | 5 | Issued entry index |
| iss_class | output | 3 | Issued entry class |
| iss_addr | output | ADDR_W | Issued entry address |

## Verification
Every ordered pair of the five classes is allocated back to back. This shows whether two classes share a resource (one issue until a release) or do not (two issues), and it checks the first entry's two-edge latency on each pass. Repeated requests to a single address exercise parking behind an older entry, a retire aimed at an entry that is not complete, a response arriving for a parked entry, and wake-up on retire. Four entries waiting on one resource, with the lowest slot refilled, tell a rotating pointer apart from fixed lowest-first priority. Filling every slot separates the reject caused by a full table from the reject caused by an unmatched response.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [2:0] {
    ST_FREE   = 3'd0,
    ST_PEND   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_ISSUED = 3'd3,
    ST_DONE   = 3'd4
  } ent_state_e;

  typedef enum logic [1:0] {
    DK_ALLOC  = 2'd0,
    DK_SERIAL = 2'd1,
    DK_MERGE  = 2'd2,
    DK_REJECT = 2'd3
  } dec_kind_e;

  // class to resource: spread classes evenly over resources
  function automatic int unsigned cls2res(input int unsigned cls,
                                          input int unsigned ncls,
                                          input int unsigned nres);
    return (cls * nres) / ncls;
  endfunction
endpackage

// File: rtl/txn_first_set.sv
module txn_first_set #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/txn_cam_match.sv
module txn_cam_match #(
  parameter int N      = 32,
  parameter int ADDR_W = 16,
  parameter int IW     = $clog2(N)
) (
  input  logic [ADDR_W-1:0]        key,
  input  logic [N-1:0][ADDR_W-1:0] addrs,
  input  logic [N-1:0]             tail_vec,
  input  logic [N-1:0]             issued_vec,
  output logic                     tail_hit,
  output logic [IW-1:0]            tail_idx,
  output logic                     iss_hit,
  output logic [IW-1:0]            iss_idx
);
  logic [N-1:0] eq, t_eq, i_eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g]   = (addrs[g] == key);
    assign t_eq[g] = eq[g] & tail_vec[g];
    assign i_eq[g] = eq[g] & issued_vec[g];
  end

  txn_first_set #(.N(N), .IW(IW)) u_tail (.vec(t_eq), .hit(tail_hit), .idx(tail_idx));
  txn_first_set #(.N(N), .IW(IW)) u_iss  (.vec(i_eq), .hit(iss_hit),  .idx(iss_idx));
endmodule

// File: rtl/txn_rr_pick.sv
module txn_rr_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  logic [N-1:0]  upper;
  logic          up_hit, any_hit;
  logic [IW-1:0] up_idx, any_idx;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign upper[g] = req[g] & (IW'(g) >= ptr);
  end

  txn_first_set #(.N(N), .IW(IW)) u_up  (.vec(upper), .hit(up_hit),  .idx(up_idx));
  txn_first_set #(.N(N), .IW(IW)) u_all (.vec(req),   .hit(any_hit), .idx(any_idx));

  assign gnt_vld = any_hit;
  assign gnt_idx = up_hit ? up_idx : any_idx;
endmodule

// File: rtl/txn_scoreboard.sv
module txn_scoreboard #(
  parameter int N_RES = 3,
  parameter int RW    = $clog2(N_RES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_vld,
  input  logic [RW-1:0]    set_res,
  input  logic [N_RES-1:0] release_vec,
  output logic [N_RES-1:0] busy
);
  logic [N_RES-1:0] set_1h;

  always_comb begin
    set_1h = '0;
    if (set_vld) set_1h[set_res] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~release_vec) | set_1h;
  end

  // R8: a grant never lands on a resource that is already held
  a_r8_no_double_book: assert property (@(posedge clk) disable iff (rst)
    set_vld |-> !busy[set_res]);
endmodule

// File: rtl/txn_inflight_table.sv
module txn_inflight_table
  import txn_pkg::*;
#(
  parameter int N_ENT   = 32,
  parameter int ADDR_W  = 16,
  parameter int N_CLASS = 5,
  parameter int N_RES   = 3,
  parameter int COH_W   = 2,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int CLS_W  = $clog2(N_CLASS),
  localparam int RES_W  = $clog2(N_RES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_is_resp,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CLS_W-1:0]  in_class,
  input  logic [COH_W-1:0]  in_coh,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_idx,
  input  logic [N_RES-1:0]  res_release,
  output logic              dec_valid,
  output logic [1:0]        dec_kind,
  output logic [IDX_W-1:0]  dec_idx,
  output logic [COH_W-1:0]  dec_coh,
  output logic              iss_valid,
  output logic [IDX_W-1:0]  iss_idx,
  output logic [CLS_W-1:0]  iss_class,
  output logic [ADDR_W-1:0] iss_addr
);
  function automatic logic [RES_W-1:0] res_of(input logic [CLS_W-1:0] c);
    return RES_W'(cls2res(int'(c), N_CLASS, N_RES));
  endfunction

  // entry storage
  ent_state_e                    ent_st  [N_ENT];
  logic [N_ENT-1:0][ADDR_W-1:0]  ent_addr;
  logic [CLS_W-1:0]              ent_cls [N_ENT];
  logic [COH_W-1:0]              ent_coh [N_ENT];
  logic [IDX_W-1:0]              ent_dep [N_ENT];
  logic [N_ENT-1:0]              ent_tail;

  // issue pipeline stage 1 and pointer
  logic              s1_vld;
  logic [IDX_W-1:0]  s1_idx;
  logic [RES_W-1:0]  s1_res;
  logic [IDX_W-1:0]  rr_ptr;
  logic [N_RES-1:0]  sb_busy;

  logic [N_ENT-1:0]  live_vec, issued_vec, elig;

  for (genvar g = 0; g < N_ENT; g++) begin : g_vec
    logic [RES_W-1:0] r;
    assign r             = res_of(ent_cls[g]);
    assign live_vec[g]   = (ent_st[g] != ST_FREE);
    assign issued_vec[g] = (ent_st[g] == ST_ISSUED);
    // exclude the pick in flight and its resource (committed next edge)
    assign elig[g] = (ent_st[g] == ST_PEND) && !sb_busy[r] &&
                     !(s1_vld && ((s1_idx == IDX_W'(g)) || (s1_res == r)));
  end

  // lookup and free slot
  logic             t_hit, m_hit, f_hit;
  logic [IDX_W-1:0] t_idx, m_idx, f_idx;

  txn_cam_match #(.N(N_ENT), .ADDR_W(ADDR_W), .IW(IDX_W)) u_cam (
    .key(in_addr), .addrs(ent_addr), .tail_vec(ent_tail), .issued_vec(issued_vec),
    .tail_hit(t_hit), .tail_idx(t_idx), .iss_hit(m_hit), .iss_idx(m_idx));

  txn_first_set #(.N(N_ENT), .IW(IDX_W)) u_free (
    .vec(~live_vec), .hit(f_hit), .idx(f_idx));

  // issue pick
  logic             pk_vld;
  logic [IDX_W-1:0] pk_idx;

  txn_rr_pick #(.N(N_ENT), .IW(IDX_W)) u_pick (
    .req(elig), .ptr(rr_ptr), .gnt_vld(pk_vld), .gnt_idx(pk_idx));

  txn_scoreboard #(.N_RES(N_RES), .RW(RES_W)) u_sb (
    .clk(clk), .rst(rst), .set_vld(s1_vld), .set_res(s1_res),
    .release_vec(res_release), .busy(sb_busy));

  // decision
  logic       ret_ok, chain, do_alloc, do_serial, do_merge;
  dec_kind_e  dk;

  always_comb begin
    ret_ok    = ret_valid && (ent_st[ret_idx] == ST_DONE);
    chain     = t_hit && !(ret_ok && (ret_idx == t_idx));
    do_alloc  = 1'b0;
    do_serial = 1'b0;
    do_merge  = 1'b0;
    dk        = DK_REJECT;
    if (in_valid && in_is_resp) begin
      if (m_hit) begin
        do_merge = 1'b1;
        dk       = DK_MERGE;
      end
    end else if (in_valid && f_hit) begin
      if (chain) begin
        do_serial = 1'b1;
        dk        = DK_SERIAL;
      end else begin
        do_alloc = 1'b1;
        dk       = DK_ALLOC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) begin
        ent_st[i]  <= ST_FREE;
        ent_cls[i] <= '0;
        ent_coh[i] <= '0;
        ent_dep[i] <= '0;
      end
      ent_addr  <= '0;
      ent_tail  <= '0;
      s1_vld    <= 1'b0;
      s1_idx    <= '0;
      s1_res    <= '0;
      rr_ptr    <= '0;
      dec_valid <= 1'b0;
      dec_kind  <= '0;
      dec_idx   <= '0;
      dec_coh   <= '0;
      iss_valid <= 1'b0;
      iss_idx   <= '0;
      iss_class <= '0;
      iss_addr  <= '0;
    end else begin
      // retire and wake dependants
      if (ret_ok) begin
        ent_st[ret_idx]   <= ST_FREE;
        ent_tail[ret_idx] <= 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
          if (ent_st[i] == ST_WAIT && ent_dep[i] == ret_idx) ent_st[i] <= ST_PEND;
        end
      end
      // stage 2: commit last cycle's pick
      iss_valid <= s1_vld;
      if (s1_vld) begin
        ent_st[s1_idx] <= ST_ISSUED;
        iss_idx        <= s1_idx;
        iss_class      <= ent_cls[s1_idx];
        iss_addr       <= ent_addr[s1_idx];
      end
      // stage 1: pick
      s1_vld <= pk_vld;
      if (pk_vld) begin
        s1_idx <= pk_idx;
        s1_res <= res_of(ent_cls[pk_idx]);
        rr_ptr <= (pk_idx == IDX_W'(N_ENT - 1)) ? '0 : pk_idx + 1'b1;
      end
      // incoming transaction
      dec_valid <= in_valid;
      dec_kind  <= dk;
      dec_idx   <= do_merge ? m_idx : ((do_alloc || do_serial) ? f_idx : '0);
      dec_coh   <= do_merge ? ent_coh[m_idx] : '0;
      if (do_alloc || do_serial) begin
        ent_st[f_idx]   <= do_serial ? ST_WAIT : ST_PEND;
        ent_addr[f_idx] <= in_addr;
        ent_cls[f_idx]  <= in_class;
        ent_coh[f_idx]  <= in_coh;
        ent_dep[f_idx]  <= t_idx;
        ent_tail[f_idx] <= 1'b1;
        if (do_serial) ent_tail[t_idx] <= 1'b0;
      end
      if (do_merge) ent_st[m_idx] <= ST_DONE;
    end
  end

  // R1: outputs idle on the edge after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> !iss_valid && !dec_valid);

  // R7: every stage-1 pick is issued on the following edge
  a_r7_pick_commits: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> iss_valid && (iss_idx == $past(s1_idx)));

  // R8: the pick stage never repeats the entry still in flight
  a_r8_no_repick: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> !(s1_vld && (s1_idx == $past(s1_idx))));

  // R6: an issued entry holds its resource in the scoreboard
  a_r6_res_held: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> sb_busy[res_of(iss_class)]);
endmodule

// File: tb/tb_txn_inflight_table.sv
`timescale 1ns/1ps
module tb_txn_inflight_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_is_resp = 1'b0;
  logic [15:0] in_addr = '0;
  logic [2:0]  in_class = '0;
  logic [1:0]  in_coh = '0;
  logic        ret_valid = 1'b0;
  logic [4:0]  ret_idx = '0;
  logic [2:0]  res_release = '0;
  logic        dec_valid, iss_valid;
  logic [1:0]  dec_kind, dec_coh;
  logic [4:0]  dec_idx, iss_idx;
  logic [2:0]  iss_class;
  logic [15:0] iss_addr;

  txn_inflight_table dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, n_iss = 0, last_idx = -1, dec_cyc = 0;
  int iss_cyc [32];
  int iss_cls [32];
  int iss_adr [32];
  bit ent_iss [32];
  bit rb [3];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int res_of(input int c);
    return c * 3 / 5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // issue monitor: R8 bookkeeping
  always @(negedge clk) begin
    if (!rst && iss_valid) begin
      int r;
      r = res_of(int'(iss_class));
      chk(!ent_iss[iss_idx], "R8", "entry issued twice", int'(iss_idx), -1);
      chk(!rb[r], "R8", "resource granted twice", r, -1);
      ent_iss[iss_idx] = 1'b1;
      rb[r] = 1'b1;
      iss_cyc[iss_idx] = cyc;
      iss_cls[iss_idx] = int'(iss_class);
      iss_adr[iss_idx] = int'(iss_addr);
      last_idx = int'(iss_idx);
      n_iss++;
    end
  end

  task automatic send(input bit resp, input int a, input int c, input int h,
                      input int ek, input int ei, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_is_resp = resp; in_addr = 16'(a);
    in_class = 3'(c); in_coh = 2'(h);
    @(negedge clk);
    in_valid = 1'b0;
    dec_cyc = cyc;
    chk(dec_valid && int'(dec_kind) == ek && (ek == 3 || int'(dec_idx) == ei), tag,
        "decision kind*100+idx", int'(dec_kind) * 100 + int'(dec_idx), ek * 100 + ei);
    if (ek == 2) chk(int'(dec_coh) == h, tag, "merge coherence", int'(dec_coh), h);
  endtask

  task automatic retire(input int idx, input bit real_done);
    @(negedge clk);
    ret_valid = 1'b1; ret_idx = 5'(idx);
    if (real_done) ent_iss[idx] = 1'b0;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic release_all();
    @(negedge clk);
    res_release = 3'b111;
    for (int r = 0; r < 3; r++) rb[r] = 1'b0;
    @(negedge clk);
    res_release = 3'b000;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!dec_valid, "R1", "dec_valid after reset", int'(dec_valid), 0);
    chk(!iss_valid, "R1", "iss_valid after reset", int'(iss_valid), 0);

    // R2 R6 R7: every ordered class pair
    for (int ca = 0; ca < 5; ca++) begin
      for (int cb = 0; cb < 5; cb++) begin
        int a, b, ha, hb, e0, ex;
        a = 'h1000 + ca * 16 + cb; b = 'h2000 + ca * 16 + cb;
        ha = (ca + cb) % 4; hb = (ca + 2 * cb + 1) % 4;
        base = n_iss;
        send(0, a, ca, ha, 0, 0, "R2");
        e0 = dec_cyc;
        send(0, b, cb, hb, 0, 1, "R2");
        idle(6);
        ex = (res_of(ca) != res_of(cb)) ? 2 : 1;
        chk(n_iss - base == ex, "R6", "issues before release", n_iss - base, ex);
        chk(iss_cyc[0] == e0 + 2, "R7", "issue latency", iss_cyc[0] - e0, 2);
        chk(iss_cls[0] == ca && iss_adr[0] == a, "R7", "issued class", iss_cls[0], ca);
        release_all();
        idle(6);
        chk(n_iss - base == 2, "R6", "issues after release", n_iss - base, 2);
        send(1, a, 0, ha, 2, 0, "R4");
        send(1, b, 0, hb, 2, 1, "R4");
        retire(0, 1); retire(1, 1);
        release_all();
      end
    end

    // R3 R10 serialization on one address
    base = n_iss;
    send(0, 'h3000, 2, 1, 0, 0, "R2");
    send(0, 'h3000, 2, 3, 1, 1, "R3");
    idle(5);
    chk(n_iss == base + 1 && last_idx == 0, "R3", "only older issued", n_iss - base, 1);
    release_all();
    idle(5);
    chk(n_iss == base + 1, "R3", "parked entry held", n_iss - base, 1);
    retire(0, 0);
    send(0, 'h3100, 4, 2, 0, 2, "R10");
    idle(5);
    send(1, 'h3000, 0, 1, 2, 0, "R4");
    send(1, 'h3000, 0, 0, 3, 0, "R5");
    retire(0, 1);
    idle(5);
    chk(n_iss == base + 3 && last_idx == 1, "R3", "wake after retire", last_idx, 1);
    send(0, 'h3000, 2, 0, 1, 0, "R3");
    release_all();
    idle(5);
    chk(n_iss == base + 3, "R3", "second parked held", n_iss - base, 3);
    send(1, 'h3000, 0, 3, 2, 1, "R4");
    retire(1, 1);
    idle(5);
    chk(n_iss == base + 4 && last_idx == 0, "R3", "chain wake", last_idx, 0);
    send(1, 'h3000, 0, 0, 2, 0, "R4");
    retire(0, 1);
    send(1, 'h3100, 0, 2, 2, 2, "R4");
    retire(2, 1);
    release_all();

    // R5 unmatched response leaves table unchanged
    send(1, 'h4444, 0, 0, 3, 0, "R5");
    send(0, 'h4444, 1, 2, 0, 0, "R5");
    idle(5);
    send(1, 'h4444, 0, 2, 2, 0, "R4");
    retire(0, 1);
    release_all();

    // R9 rotating priority
    for (int i = 0; i < 4; i++) send(0, 'h5000 + i, i % 2, 0, 0, i, "R2");
    idle(5);
    chk(last_idx == 0, "R9", "first issue", last_idx, 0);
    send(1, 'h5000, 0, 0, 2, 0, "R4");
    retire(0, 1);
    send(0, 'h5010, 1, 0, 0, 0, "R2");
    for (int k = 1; k <= 4; k++) begin
      release_all();
      idle(5);
      chk(last_idx == k % 4, "R9", "rotation order", last_idx, k % 4);
    end

    // R5 full table
    for (int i = 0; i < 28; i++) send(0, 'h6000 + i, 4, 0, 0, 4 + i, "R2");
    send(0, 'h7000, 4, 0, 3, 0, "R5");
    send(0, 'h6000, 4, 0, 3, 0, "R5");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule